// File: doc/BRIEF.md
# Windowed Multithreaded Integer Register File

This block holds the integer registers of four hardware threads that share one pipeline. Each thread has its own register contents: eight non-windowed globals and a stack of eight register windows. Every window has eight in, eight local and eight out registers. The out group of one window is the same storage as the in group of the window above it, so a caller's arguments appear in the callee's ins without any copying. The threads share all of the port logic: three combinational read ports and two write ports. One write port serves normal writeback and the other serves late results from long-latency units.

Each access carries a thread number and a 5-bit architectural register number. The block turns this pair into a physical entry through that thread's current window pointer. A call strobe moves the pointer of one thread up by one window and a return strobe moves it down by one. A successful move raises a one-cycle switch request for that thread, so the scheduler can issue from another thread while the window settles. A call at the top window or a return at the bottom window does not move the pointer. It raises an overflow or underflow pulse, which the surrounding trap logic handles.

Top module: `win_regfile`

## Requirements
- R1: After reset every window pointer is 0, `sw_req`, `win_ovf` and `win_unf` are all 0, and every register of every thread reads 0.
- R2: Register numbers map as follows: 0 to 7 are globals, 8 to 15 are outs, 16 to 23 are locals and 24 to 31 are ins. The globals are the same in every window of a thread. Locals are private to their window. Out register 8+k of window w is the same storage as in register 24+k of window (w+1) mod 8.
- R3: Threads never share register contents. A write by one thread is never visible to another thread.
- R4: Register 0 always reads 0. A write to it has no effect on any register.
- R5: Each of the three read ports returns, in the same cycle and without a clock edge, the register that its own thread and register number select.
- R6: A write on either port takes effect at the next rising clock edge. When both ports write the same physical register in one cycle, port 1 (the late-result port) wins.
- R7: A read of a register that is being written in the same cycle returns the new data. If both ports write it, the read returns port 1's data.
- R8: `win_call` raises the pointer of thread `win_tid` by one at the next edge, and `win_ret` lowers it by one. When both are asserted, only the call acts. The pointers of the other threads do not change.
- R9: Each pointer move sets `sw_req[win_tid]` to 1 for exactly the cycle after the edge that applies the move. `sw_req` is 0 in all other cycles.
- R10: A call while the pointer is 7 leaves the pointer unchanged, raises `win_ovf[win_tid]` for one cycle and raises no switch request.
- R11: A return while the pointer is 0 leaves the pointer unchanged, raises `win_unf[win_tid]` for one cycle and raises no switch request.
- R12: Reads and writes made in the same cycle as a window move use the old window. The new window applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_tid | input | 3x2 | Thread of each read port |
| rd_reg | input | 3x5 | Architectural register of each read port |
| rd_data | output | 3x32 | Read data of each port |
| wr_en | input | 2 | Write enable per write port |
| wr_tid | input | 2x2 | Thread of each write port |
| wr_reg | input | 2x5 | Architectural register of each write port |
| wr_data | input | 2x32 | Write data per port |
| win_call | input | 1 | Move the window of `win_tid` up |
| win_ret | input | 1 | Move the window of `win_tid` down |
| win_tid | input | 2 | Thread whose window moves |
| win_ptr | output | 4x3 | Current window pointer of each thread |
| sw_req | output | 4 | One-cycle thread-switch request per thread |
| win_ovf | output | 4 | One-cycle overflow pulse per thread |
| win_unf | output | 4 | One-cycle underflow pulse per thread |

## Verification
The hardest case to reach is the wrap-around alias, where the outs of window 7 are the ins of window 0. Only a thread that has climbed through seven successful calls reaches it. For every thread, the stimulus climbs the full window stack one call at a time. At each level it writes all 32 register numbers and reads the whole file back. It then calls once more at the top to force an overflow, and descends to the bottom with a full readback after every return. A final return forces an underflow. The expected contents come from an arithmetic model of the mapping, so every alias and every cross-thread separation is compared at each level.

// File: rtl/win_regfile.sv
module win_regfile #(
  parameter int NTHR = 4,
  parameter int NWIN = 8,
  parameter int DW   = 32,
  parameter int NRD  = 3,
  parameter int NWR  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NRD-1:0][$clog2(NTHR)-1:0] rd_tid,
  input  logic [NRD-1:0][4:0]        rd_reg,
  output logic [NRD-1:0][DW-1:0]     rd_data,
  input  logic [NWR-1:0]             wr_en,
  input  logic [NWR-1:0][$clog2(NTHR)-1:0] wr_tid,
  input  logic [NWR-1:0][4:0]        wr_reg,
  input  logic [NWR-1:0][DW-1:0]     wr_data,
  input  logic                       win_call,
  input  logic                       win_ret,
  input  logic [$clog2(NTHR)-1:0]    win_tid,
  output logic [NTHR-1:0][$clog2(NWIN)-1:0] win_ptr,
  output logic [NTHR-1:0]            sw_req,
  output logic [NTHR-1:0]            win_ovf,
  output logic [NTHR-1:0]            win_unf
);

  localparam int TW    = $clog2(NTHR);
  localparam int WW    = $clog2(NWIN);
  localparam int GRP   = 8;
  localparam int TSZ   = GRP + 2 * GRP * NWIN;
  localparam int NPHYS = NTHR * TSZ;
  localparam int PW    = $clog2(NPHYS);

  logic [DW-1:0] mem [NPHYS];
  logic [NTHR-1:0][WW-1:0] cwp;
  logic [NRD-1:0][PW-1:0] ra;
  logic [NWR-1:0][PW-1:0] wa;

  function automatic logic [PW-1:0] map_reg(input logic [TW-1:0] t,
                                            input logic [4:0] r,
                                            input logic [WW-1:0] w);
    logic [WW-1:0] wn;
    int off;
    wn = w + WW'(1);
    case (r[4:3])
      2'd0:    off = int'(r[2:0]);
      2'd1:    off = GRP + (int'(wn) * 2 + 1) * GRP + int'(r[2:0]);
      2'd2:    off = GRP + int'(w) * 2 * GRP + int'(r[2:0]);
      default: off = GRP + (int'(w) * 2 + 1) * GRP + int'(r[2:0]);
    endcase
    return PW'(int'(t) * TSZ + off);
  endfunction

  assign win_ptr = cwp;

  always_comb begin
    for (int j = 0; j < NWR; j++)
      wa[j] = map_reg(wr_tid[j], wr_reg[j], cwp[wr_tid[j]]);
  end

  always_comb begin
    for (int i = 0; i < NRD; i++) begin
      ra[i] = map_reg(rd_tid[i], rd_reg[i], cwp[rd_tid[i]]);
      rd_data[i] = mem[ra[i]];
      for (int j = 0; j < NWR; j++)
        if (wr_en[j] && wr_reg[j] != 5'd0 && wa[j] == ra[i])
          rd_data[i] = wr_data[j];
      if (rd_reg[i] == 5'd0)
        rd_data[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NPHYS; k++) mem[k] <= '0;
    end else begin
      for (int j = 0; j < NWR; j++)
        if (wr_en[j] && wr_reg[j] != 5'd0)
          mem[wa[j]] <= wr_data[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp     <= '0;
      sw_req  <= '0;
      win_ovf <= '0;
      win_unf <= '0;
    end else begin
      sw_req  <= '0;
      win_ovf <= '0;
      win_unf <= '0;
      if (win_call) begin
        if (cwp[win_tid] == WW'(NWIN - 1)) begin
          win_ovf[win_tid] <= 1'b1;
        end else begin
          cwp[win_tid]    <= cwp[win_tid] + WW'(1);
          sw_req[win_tid] <= 1'b1;
        end
      end else if (win_ret) begin
        if (cwp[win_tid] == '0) begin
          win_unf[win_tid] <= 1'b1;
        end else begin
          cwp[win_tid]    <= cwp[win_tid] - WW'(1);
          sw_req[win_tid] <= 1'b1;
        end
      end
    end
  end

  // R9
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_req | win_ovf | win_unf));

  for (genvar t = 0; t < NTHR; t++) begin : g_thr_chk
    // R9
    sw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req[t] |-> (win_ptr[t] == $past(win_ptr[t]) + WW'(1)) ||
                    (win_ptr[t] == $past(win_ptr[t]) - WW'(1)));
    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_req[t] |-> $stable(win_ptr[t]));
    // R10
    ovf_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_ovf[t] |-> $stable(win_ptr[t]) && win_ptr[t] == WW'(NWIN - 1));
    // R11
    unf_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_unf[t] |-> $stable(win_ptr[t]) && win_ptr[t] == '0);
  end

  for (genvar i = 0; i < NRD; i++) begin : g_rd_chk
    // R4
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_reg[i] == 5'd0 |-> rd_data[i] == '0);
  end

endmodule

// File: tb/test_win_regfile.sv
module test_win_regfile;
  localparam int CLK_P = 10;
  localparam int NT = 4;
  localparam int NW = 8;
  localparam int TS = 8 + 16 * NW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0][1:0]  rd_tid = '0;
  logic [2:0][4:0]  rd_reg = '0;
  logic [2:0][31:0] rd_data;
  logic [1:0]       wr_en = '0;
  logic [1:0][1:0]  wr_tid = '0;
  logic [1:0][4:0]  wr_reg = '0;
  logic [1:0][31:0] wr_data = '0;
  logic win_call = 1'b0, win_ret = 1'b0;
  logic [1:0] win_tid = '0;
  logic [3:0][2:0] win_ptr;
  logic [3:0] sw_req, win_ovf, win_unf;

  int checks = 0, errors = 0;
  logic [31:0] model [NT*TS];
  int bw [NT];

  always #(CLK_P/2) clk = ~clk;

  win_regfile i_win_regfile (
    .clk(clk), .rst_n(rst_n), .rd_tid(rd_tid), .rd_reg(rd_reg), .rd_data(rd_data),
    .wr_en(wr_en), .wr_tid(wr_tid), .wr_reg(wr_reg), .wr_data(wr_data),
    .win_call(win_call), .win_ret(win_ret), .win_tid(win_tid),
    .win_ptr(win_ptr), .sw_req(sw_req), .win_ovf(win_ovf), .win_unf(win_unf));

  function automatic int bphys(int t, int r, int w);
    int base = t * TS;
    if (r < 8)  return base + r;
    if (r < 16) return base + 8 + ((w + 1) % NW) * 16 + 8 + (r - 8);
    if (r < 24) return base + 8 + w * 16 + (r - 16);
    return base + 8 + w * 16 + 8 + (r - 24);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdchk(int port, int t, int r, string tag);
    logic [31:0] exp;
    @(negedge clk);
    rd_tid[port] = 2'(t);
    rd_reg[port] = 5'(r);
    #1;
    exp = (r == 0) ? 32'h0 : model[bphys(t, r, bw[t])];
    chk($sformatf("%s t%0d r%0d port%0d", tag, t, r, port), rd_data[port], exp);
  endtask

  task automatic readall(string tag);
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < 32; r++)
        rdchk((t + r) % 3, t, r, tag);
  endtask

  task automatic wr2(int t, int ra, logic [31:0] da, int rb, logic [31:0] db);
    @(negedge clk);
    wr_en = 2'b11;
    wr_tid[0] = 2'(t); wr_reg[0] = 5'(ra); wr_data[0] = da;
    wr_tid[1] = 2'(t); wr_reg[1] = 5'(rb); wr_data[1] = db;
    if (ra != 0) model[bphys(t, ra, bw[t])] = da;
    if (rb != 0) model[bphys(t, rb, bw[t])] = db;
    @(posedge clk); #1;
    wr_en = 2'b00;
  endtask

  task automatic winop(int t, bit call, bit ret, string tag);
    logic [3:0] e_sw, e_ovf, e_unf;
    e_sw = '0; e_ovf = '0; e_unf = '0;
    if (call) begin
      if (bw[t] == NW - 1) e_ovf[t] = 1'b1;
      else begin bw[t]++; e_sw[t] = 1'b1; end
    end else if (ret) begin
      if (bw[t] == 0) e_unf[t] = 1'b1;
      else begin bw[t]--; e_sw[t] = 1'b1; end
    end
    @(negedge clk);
    win_tid = 2'(t); win_call = call; win_ret = ret;
    @(posedge clk); #1;
    win_call = 1'b0; win_ret = 1'b0;
    chk({tag, " sw_req"}, 32'(sw_req), 32'(e_sw));
    chk({tag, " ovf"}, 32'(win_ovf), 32'(e_ovf));
    chk({tag, " unf"}, 32'(win_unf), 32'(e_unf));
    chk({tag, " ptr"}, 32'(win_ptr[t]), 32'(bw[t]));
    @(posedge clk); #1;
    chk({tag, " sw_req one cycle"}, 32'(sw_req | win_ovf | win_unf), 32'h0);
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int k = 0; k < NT*TS; k++) model[k] = '0;
    for (int t = 0; t < NT; t++) bw[t] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 ptrs", 32'(win_ptr), 32'h0);
    chk("R1 flags", 32'({sw_req, win_ovf, win_unf}), 32'h0);
    readall("R1 reset contents");

    // R2 R3 R4 R5 R6 R8 R9 R10 R11: full climb and descent per thread
    for (int t = 0; t < NT; t++) begin
      for (int w = 0; w < NW; w++) begin
        for (int r = 0; r < 16; r++)
          wr2(t, r, {8'(t), 8'(w), 8'(r), 8'h5A}, r + 16, {8'(t), 8'(w), 8'(r + 16), 8'hC3});
        readall("R2 climb readback");
        if (w < NW - 1) winop(t, 1'b1, 1'b0, "R8 call");
      end
      winop(t, 1'b1, 1'b0, "R10 call at top");
      readall("R10 contents after overflow");
      for (int w = NW - 1; w > 0; w--) begin
        winop(t, 1'b0, 1'b1, "R8 return");
        readall("R2 descent readback");
      end
      winop(t, 1'b0, 1'b1, "R11 return at bottom");
    end

    // R7 write-first bypass and R6 port 1 priority
    @(negedge clk);
    wr_en = 2'b11;
    wr_tid[0] = 2'd1; wr_reg[0] = 5'd17; wr_data[0] = 32'h1111_0001;
    wr_tid[1] = 2'd1; wr_reg[1] = 5'd17; wr_data[1] = 32'h2222_0002;
    rd_tid[2] = 2'd1; rd_reg[2] = 5'd17;
    rd_tid[0] = 2'd1; rd_reg[0] = 5'd25;
    #1;
    chk("R7 bypass both ports", rd_data[2], 32'h2222_0002);
    chk("R7 unrelated read", rd_data[0], model[bphys(1, 25, bw[1])]);
    model[bphys(1, 17, bw[1])] = 32'h2222_0002;
    @(posedge clk); #1;
    wr_en = 2'b01;
    wr_reg[0] = 5'd18; wr_data[0] = 32'h3333_0003;
    rd_tid[1] = 2'd1; rd_reg[1] = 5'd18;
    #1;
    chk("R7 bypass port 0", rd_data[1], 32'h3333_0003);
    model[bphys(1, 18, bw[1])] = 32'h3333_0003;
    @(posedge clk); #1;
    wr_en = 2'b00;
    rdchk(1, 1, 17, "R6 port 1 wins");
    rdchk(0, 1, 18, "R6 port 0 stored");

    // R4 write to register 0 ignored
    wr2(0, 0, 32'hDEAD_BEEF, 0, 32'hFEED_0000);
    readall("R4 zero write ignored");

    // R12 write in same cycle as call uses old window
    @(negedge clk);
    wr_en = 2'b01; wr_tid[0] = 2'd2; wr_reg[0] = 5'd16; wr_data[0] = 32'h4444_0004;
    win_tid = 2'd2; win_call = 1'b1;
    model[bphys(2, 16, bw[2])] = 32'h4444_0004;
    bw[2]++;
    @(posedge clk); #1;
    wr_en = 2'b00; win_call = 1'b0;
    chk("R12 ptr moved", 32'(win_ptr[2]), 32'd1);
    rdchk(0, 2, 16, "R12 new window local");
    winop(2, 1'b0, 1'b1, "R12 return");
    rdchk(1, 2, 16, "R12 old window local");
    chk("R12 old local value", rd_data[1], 32'h4444_0004);

    // R8 call and return together: call wins
    winop(3, 1'b1, 1'b1, "R8 call+ret");
    chk("R8 other ptrs", 32'({win_ptr[2], win_ptr[1], win_ptr[0]}), 32'h0);
    readall("R3 final contents");

    d = 32'(checks);
    $display("Simulation finished: %0d checks, %0d errors", d, errors);
    $finish;
  end
endmodule